// File: doc/BRIEF.md
# Page Reference History Aging Unit

This block tracks how recently each of a set of physical page frames has been used. It keeps one sticky reference bit and one short usage history per frame. Whenever the memory system touches a frame, it pulses that frame's bit on `ref_vec`, and the frame's reference bit is set. Software or a timer raises `tick` once per sampling period. On that edge each frame's reference bit is pushed into the top of its history, the older history moves one place toward the bottom, and the reference bit starts the new period.

Read as an unsigned number, a larger history means more recent and more frequent use. The block compares all histories every cycle without a clock delay and reports the frame with the smallest value as the replacement candidate. This gives a cheap approximation of least-recently-used replacement without timestamps.

Top module: `page_age_tracker`

## Requirements
- R1: While `rst_n` is low, every reference bit and every history is cleared to 0, so `ref_state` and `hist_flat` read 0 and `victim_idx` reads 0.
- R2: When `ref_vec[i]` is high in a cycle where `tick` is low, `ref_state[i]` is 1 after that edge and stays 1 until the next tick edge.
- R3: On a tick edge, the most significant bit of frame i's history takes the value `ref_state[i]` held before that edge.
- R4: On a tick edge, the rest of each history moves one place toward bit 0, and the old bit 0 is dropped.
- R5: On a tick edge, `ref_state[i]` becomes `ref_vec[i]` as sampled on that same edge. A reference that arrives in the tick cycle is therefore counted in the following period, and every other reference bit is cleared.
- R6: A history does not change on an edge where `tick` is low.
- R7: `victim_idx` is the index of the frame whose history is the smallest unsigned value, and `victim_hist` is that value. Both follow the current histories with no cycle of delay.
- R8: When several frames share the smallest history, `victim_idx` is the lowest of their indices.
- R9: A frame referenced in each of 8 consecutive periods reads 8'hFF after the 8th tick. A frame not referenced in 8 consecutive periods reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Period boundary strobe, one cycle per period |
| ref_vec | input | FRAMES | Per-frame access pulses |
| ref_state | output | FRAMES | Current reference bit of each frame |
| hist_flat | output | FRAMES*HIST_W | Histories; frame i at bits [HIST_W*i+HIST_W-1 : HIST_W*i] |
| victim_idx | output | IDX_W | Frame with the smallest history |
| victim_hist | output | HIST_W | History value of that frame |

## Verification
The bench first sets reference bits in ordinary cycles with no tick edge. This separates the sticky set from the history shift, since the histories must stay unchanged. Single ticks after distinct reference masks show whether the MSB is loaded and whether older bits move down correctly. A reference that coincides with the tick shows whether it is carried into the next period rather than lost or applied early. Eight periods of steady use, and then eight of idleness, take a history to all ones and then back to zero. Mixed masks then produce unique minima, ties, and a minimum at frame 0, which confirm the victim search and its tie-break toward the lowest index.

// File: rtl/page_age_tracker.sv
module page_age_tracker #(
  parameter int FRAMES = 8,
  parameter int HIST_W = 8,
  localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic [FRAMES-1:0]          ref_vec,
  output logic [FRAMES-1:0]          ref_state,
  output logic [FRAMES*HIST_W-1:0]   hist_flat,
  output logic [IDX_W-1:0]           victim_idx,
  output logic [HIST_W-1:0]          victim_hist
);

  logic [FRAMES-1:0] ref_q;
  logic [HIST_W-1:0] hist_q [FRAMES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      for (int i = 0; i < FRAMES; i++) hist_q[i] <= '0;
    end else begin
      ref_q <= tick ? ref_vec : (ref_q | ref_vec);
      if (tick)
        for (int i = 0; i < FRAMES; i++)
          hist_q[i] <= {ref_q[i], hist_q[i][HIST_W-1:1]};
    end
  end

  assign ref_state = ref_q;

  always_comb begin
    victim_idx  = '0;
    victim_hist = hist_q[0];
    for (int i = 1; i < FRAMES; i++)
      if (hist_q[i] < victim_hist) begin
        victim_hist = hist_q[i];
        victim_idx  = IDX_W'(i);
      end
  end

  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    assign hist_flat[g*HIST_W +: HIST_W] = hist_q[g];

    // R3
    msb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> hist_q[g][HIST_W-1] == $past(ref_q[g]));
    // R4
    shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> hist_q[g][HIST_W-2:0] == $past(hist_q[g][HIST_W-1:1]));
    // R6
    hold_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(hist_q[g]));
    // R2
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && ref_vec[g]) |=> ref_q[g]);
    // R5
    ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ref_vec[g]) |=> !ref_q[g]);
    // R7
    victim_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      victim_hist <= hist_q[g]);
    // R8
    victim_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_q[g] == victim_hist) |-> (victim_idx <= IDX_W'(g)));
  end

endmodule

// File: tb/test_page_age_tracker.sv
module test_page_age_tracker;
  localparam int N = 8;
  localparam int W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0;
  logic [N-1:0] ref_vec = '0;
  logic [N-1:0] ref_state;
  logic [N*W-1:0] hist_flat;
  logic [2:0] victim_idx;
  logic [W-1:0] victim_hist;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] m_ref;
  logic [W-1:0] m_hist [N];

  always #4 clk = ~clk;

  page_age_tracker #(.FRAMES(N), .HIST_W(W)) i_page_age_tracker (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ref_vec(ref_vec),
    .ref_state(ref_state), .hist_flat(hist_flat),
    .victim_idx(victim_idx), .victim_hist(victim_hist));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    int bi;
    logic [W-1:0] bv;
    bi = 0;
    bv = m_hist[0];
    for (int i = 1; i < N; i++)
      if (m_hist[i] < bv) begin bv = m_hist[i]; bi = i; end
    check(req, "ref_state", int'(ref_state), int'(m_ref));
    for (int i = 0; i < N; i++)
      check(req, $sformatf("hist[%0d]", i), int'(hist_flat[i*W +: W]), int'(m_hist[i]));
    check(req, "victim_idx", int'(victim_idx), bi);
    check(req, "victim_hist", int'(victim_hist), int'(bv));
  endtask

  task automatic step(logic t, logic [N-1:0] r);
    @(negedge clk);
    tick = t;
    ref_vec = r;
    @(negedge clk);
    tick = 0;
    ref_vec = '0;
    if (t) begin
      for (int i = 0; i < N; i++) m_hist[i] = {m_ref[i], m_hist[i][W-1:1]};
      m_ref = r;
    end else m_ref = m_ref | r;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    m_ref = '0;
    for (int i = 0; i < N; i++) m_hist[i] = '0;
    @(negedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1;
  endtask

  task automatic t_ref_set();
    do_reset();
    step(0, 8'b0000_0101);
    check("R2", "ref_state set", int'(ref_state), 5);
    check_all("R6");
    step(0, 8'h00);
    check("R2", "ref_state held", int'(ref_state), 5);
    check_all("R6");
  endtask

  task automatic t_tick_load();
    step(1, 8'h00);
    check("R3", "hist[0]", int'(hist_flat[0 +: W]), 8'h80);
    check("R3", "hist[2]", int'(hist_flat[2*W +: W]), 8'h80);
    check("R5", "ref cleared", int'(ref_state), 0);
    check("R8", "tie victim", int'(victim_idx), 1);
    check_all("R3");
  endtask

  task automatic t_shift();
    step(0, 8'h01);
    step(1, 8'h00);
    check("R4", "hist[0]", int'(hist_flat[0 +: W]), 8'hC0);
    check("R4", "hist[2]", int'(hist_flat[2*W +: W]), 8'h40);
    check_all("R4");
  endtask

  task automatic t_ref_on_tick();
    step(1, 8'h08);
    check("R5", "ref kept", int'(ref_state), 8'h08);
    check("R5", "hist[3] not yet", int'(hist_flat[3*W +: W]), 0);
    step(1, 8'h00);
    check("R5", "hist[3] next period", int'(hist_flat[3*W +: W]), 8'h80);
    check_all("R5");
  endtask

  task automatic t_saturate();
    do_reset();
    for (int k = 0; k < 8; k++) begin
      step(0, 8'h01);
      step(1, 8'h00);
    end
    check("R9", "all used", int'(hist_flat[0 +: W]), 8'hFF);
    check("R9", "victim not 0", int'(victim_idx), 1);
    for (int k = 0; k < 8; k++) step(1, 8'h00);
    check("R9", "all idle", int'(hist_flat[0 +: W]), 8'h00);
    check_all("R9");
  endtask

  task automatic t_victim();
    do_reset();
    step(0, 8'hBF);
    step(1, 8'h00);
    check("R7", "unique min", int'(victim_idx), 6);
    check_all("R7");
    step(0, 8'h40);
    step(1, 8'h00);
    check("R8", "tie low index", int'(victim_idx), 0);
    check_all("R8");
    step(0, 8'hFE);
    step(1, 8'h00);
    check("R7", "min frame 0", int'(victim_idx), 0);
    check("R7", "min value", int'(victim_hist), 8'h20);
    step(0, 8'h7F);
    step(1, 8'h00);
    check("R7", "min frame 7", int'(victim_idx), 7);
    check_all("R7");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_ref_set();
    t_tick_load();
    t_shift();
    t_ref_on_tick();
    t_saturate();
    t_victim();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule